// File: doc/BRIEF.md
# Pulse-Width Bit Transmitter

The block sends a data word, one bit at a time, over a single output line that idles high. Each bit is a low pulse followed by a high recovery time. A 1 is a short pulse of one time unit and a 0 is a long pulse of two units. Every bit takes the same fixed slot of three units, so the high time after a pulse is never shorter than one unit. Bits go out least significant first. A load strobe supplies the word and how many of its bits to send.

While each pulse is low, the block samples a separate reply line at a fixed offset after the falling edge. It collects these samples into a reply word, with the sample taken for bit i stored at bit position i. When the last bit's slot ends, the block raises a one-cycle done pulse and presents the reply word.

After reset the block waits out a programmable start delay and ignores loads during that wait. This lets a target that has no separate reset line finish its own power-up before the first pulse arrives. All timing comes from parameters given in microseconds together with the number of clock cycles per microsecond. In the formulas below, U is the unit in cycles, S is the sample offset in cycles, D is the start delay in cycles and N is the data width.

Top module: `pwb_tx`

## Requirements
- R1: After reset the output is high, done is low and the reply word is zero. Busy stays high until D rising clock edges have passed since reset was released, and any load seen in that time is ignored.
- R2: A bit of value 1 drives the output low for exactly U cycles. The first low cycle is the cycle right after the clock edge that accepts the load.
- R3: A bit of value 0 drives the output low for exactly 2U cycles.
- R4: Every bit takes a slot of exactly 3U cycles, and the output is high for the rest of the slot. The high time between two pulses is therefore at least U cycles.
- R5: Bits are sent least significant first, and the number sent equals the accepted count.
- R6: The reply line is sampled once per bit, on the clock edge that ends cycle S of the slot, while the output is low. The sample for bit i is stored at position i of the reply word, and positions that were not sent read zero.
- R7: Done is high for exactly one cycle, the cycle right after the last slot ends. Busy is low in that cycle. The reply word then holds its value until the next load is accepted.
- R8: A load that arrives while busy is ignored, and the bits in progress continue unchanged.
- R9: A load with a count of zero is ignored. A count larger than N is treated as N.
- R10: Whenever busy is low, the output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Strobe that starts a word |
| data_i | input | DATA_W | Word to send, least significant bit first |
| count_i | input | CNT_W | Number of bits to send |
| busy_o | output | 1 | High during the start delay and while a word is being sent |
| done_o | output | 1 | One-cycle pulse after the last bit |
| tx_o | output | 1 | Pulse-width encoded output line, idles high |
| echo_i | input | 1 | Reply line from the target |
| echo_o | output | DATA_W | Collected reply word |

## Verification
The bench sends every 8-bit word and compares each cycle of the output against the expected pulse and slot pattern. A wrong pulse length, bit order or slot length therefore shows up as a mismatch in a specific cycle. Its model of the target drives the reply bit only while the line is low and drives the inverse while the line is high, so sampling at the wrong offset stores the wrong bits. Further cases cover a load in the middle of a word, a count of zero, a count too large, and loads during the start delay. A design that restarted, stretched or shortened a word, or that came out of the start delay one cycle early or late, would show a waveform mismatch, a done pulse in the wrong cycle or a wrong ready cycle.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  // Convert a time in microseconds to clock cycles.
  function automatic int unit_cycles(input int cyc_per_us, input int us);
    return cyc_per_us * us;
  endfunction

  // Length of the low pulse: one unit for a 1, two units for a 0.
  function automatic int low_cycles(input logic bit_val, input int unit_cyc);
    return bit_val ? unit_cyc : 2 * unit_cyc;
  endfunction

  // Every bit takes the same slot of three units.
  function automatic int slot_cycles(input int unit_cyc);
    return 3 * unit_cyc;
  endfunction
endpackage

// File: rtl/pwb_start_delay.sv
module pwb_start_delay #(
  parameter int START_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  output logic ready
);
  generate
    if (START_CYC == 0) begin : g_none
      assign ready = 1'b1;
    end else begin : g_cnt
      localparam int CW = (START_CYC > 1) ? $clog2(START_CYC) : 1;
      logic [CW-1:0] cnt_q;
      logic          rdy_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
          rdy_q <= 1'b0;
        end else if (!rdy_q) begin
          if (cnt_q == CW'(START_CYC - 1)) rdy_q <= 1'b1;
          else cnt_q <= cnt_q + 1'b1;
        end
      end
      assign ready = rdy_q;
    end
  endgenerate
endmodule

// File: rtl/pwb_slot_timer.sv
module pwb_slot_timer #(
  parameter int UNIT_CYC   = 4,
  parameter int SAMPLE_CYC = 2,
  parameter int SLOT_CYC   = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic bit_val,
  output logic low_now,
  output logic sample_evt,
  output logic slot_end
);
  localparam int SC_W = $clog2(SLOT_CYC);
  logic [SC_W-1:0] sc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sc_q <= '0;
    else if (!run || slot_end) sc_q <= '0;
    else sc_q <= sc_q + 1'b1;
  end

  assign slot_end   = run && (sc_q == SC_W'(SLOT_CYC - 1));
  assign sample_evt = run && (sc_q == SC_W'(SAMPLE_CYC));
  assign low_now    = run && (int'(sc_q) < pwb_pkg::low_cycles(bit_val, UNIT_CYC));
endmodule

// File: rtl/pwb_tx.sv
module pwb_tx #(
  parameter int DATA_W         = 32,
  parameter int CNT_W          = $clog2(DATA_W + 1),
  parameter int CYC_PER_US     = 100,
  parameter int UNIT_US        = 4,
  parameter int SAMPLE_US      = 2,
  parameter int START_DELAY_US = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              tx_o,
  input  logic              echo_i,
  output logic [DATA_W-1:0] echo_o
);
  localparam int UNIT_CYC   = pwb_pkg::unit_cycles(CYC_PER_US, UNIT_US);
  localparam int SAMPLE_CYC = pwb_pkg::unit_cycles(CYC_PER_US, SAMPLE_US);
  localparam int SLOT_CYC   = pwb_pkg::slot_cycles(UNIT_CYC);
  localparam int START_CYC  = pwb_pkg::unit_cycles(CYC_PER_US, START_DELAY_US);
  localparam int IDX_W      = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic              ready, sending_q, done_q;
  logic [DATA_W-1:0] data_q, echo_q;
  logic [IDX_W-1:0]  idx_q, last_q;
  logic [CNT_W-1:0]  n_eff;
  logic              accept, low_now, sample_evt, slot_end, last_bit;

  pwb_start_delay #(.START_CYC(START_CYC)) u_start (
    .clk(clk), .rst_n(rst_n), .ready(ready)
  );

  pwb_slot_timer #(.UNIT_CYC(UNIT_CYC), .SAMPLE_CYC(SAMPLE_CYC), .SLOT_CYC(SLOT_CYC)) u_slot (
    .clk(clk), .rst_n(rst_n), .run(sending_q), .bit_val(data_q[0]),
    .low_now(low_now), .sample_evt(sample_evt), .slot_end(slot_end)
  );

  assign n_eff    = (count_i > CNT_W'(DATA_W)) ? CNT_W'(DATA_W) : count_i;
  assign accept   = load_i && ready && !sending_q && (count_i != '0);
  assign last_bit = slot_end && (idx_q == last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sending_q <= 1'b0;
      done_q    <= 1'b0;
      data_q    <= '0;
      echo_q    <= '0;
      idx_q     <= '0;
      last_q    <= '0;
    end else begin
      done_q <= last_bit;
      if (accept) begin
        sending_q <= 1'b1;
        data_q    <= data_i;
        echo_q    <= '0;
        idx_q     <= '0;
        last_q    <= IDX_W'(n_eff - CNT_W'(1));
      end else if (sending_q) begin
        if (sample_evt) echo_q[idx_q] <= echo_i;
        if (slot_end) begin
          data_q <= data_q >> 1;
          idx_q  <= idx_q + 1'b1;
          if (last_bit) sending_q <= 1'b0;
        end
      end
    end
  end

  assign busy_o = !ready || sending_q;
  assign done_o = done_q;
  assign tx_o   = !low_now;
  assign echo_o = echo_q;
endmodule

// File: rtl/pwb_tx_chk.sv
module pwb_tx_chk #(
  parameter int DATA_W   = 32,
  parameter int UNIT_CYC = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              tx_o,
  input logic [DATA_W-1:0] echo_o,
  input logic              sample_evt,
  input logic              slot_end
);
  localparam int SAT = 4 * UNIT_CYC;
  int   low_cnt, hi_cnt;
  logic seen_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt   <= 0;
      hi_cnt    <= SAT;
      seen_rise <= 1'b0;
    end else begin
      low_cnt <= tx_o ? 0 : low_cnt + 1;
      if (tx_o) hi_cnt <= (hi_cnt < SAT) ? hi_cnt + 1 : SAT;
      else hi_cnt <= 0;
      if (!tx_o) seen_rise <= 1'b1;
      if (!busy_o) seen_rise <= 1'b0;
    end
  end

  // R2 R3
  low_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_o) |-> (low_cnt == UNIT_CYC || low_cnt == 2 * UNIT_CYC));
  // R4
  high_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(tx_o) && seen_rise) |-> (hi_cnt >= UNIT_CYC));
  // R6
  sample_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_evt |-> !tx_o);
  // R7
  done_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(slot_end)));
  // R7
  echo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !load_i) |=> $stable(echo_o));
  // R10
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> tx_o);
endmodule

bind pwb_tx pwb_tx_chk #(.DATA_W(DATA_W), .UNIT_CYC(UNIT_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_i(load_i), .busy_o(busy_o), .done_o(done_o),
  .tx_o(tx_o), .echo_o(echo_o), .sample_evt(sample_evt), .slot_end(slot_end)
);

// File: tb/sim_pwb_tx.sv
module sim_pwb_tx;
  localparam int DW = 8, CW = 4, U = 4, SLOT = 12, START = 20;

  logic          clk = 1'b0, rst_n = 1'b0, load_i = 1'b0, echo_i = 1'b0;
  logic [DW-1:0] data_i = '0;
  logic [CW-1:0] count_i = '0;
  logic          busy_o, done_o, tx_o;
  logic [DW-1:0] echo_o;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [DW-1:0] reply = '0;
  int   idx = -1;
  logic prev_tx = 1'b1;

  always #5 clk = ~clk;

  pwb_tx #(.DATA_W(DW), .CNT_W(CW), .CYC_PER_US(2), .UNIT_US(2), .SAMPLE_US(1),
           .START_DELAY_US(10)) u0 (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .data_i(data_i), .count_i(count_i),
    .busy_o(busy_o), .done_o(done_o), .tx_o(tx_o), .echo_i(echo_i), .echo_o(echo_o));

  // Target model: the reply bit is valid only while the line is low.
  always @(negedge clk) begin
    if (!busy_o) idx = -1;
    else if (!tx_o && prev_tx) idx = idx + 1;
    prev_tx = tx_o;
    if (idx >= 0 && idx < DW) echo_i <= tx_o ? ~reply[idx] : reply[idx];
    else echo_i <= 1'b0;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  task automatic send(input logic [DW-1:0] d, input int n, input bit interfere);
    int nn, bad, first_bad;
    logic [DW-1:0] mask;
    nn = (n > DW) ? DW : n;
    mask = (nn >= DW) ? '1 : DW'((1 << nn) - 1);
    reply = d ^ 8'hA5;
    bad = 0; first_bad = -1;
    @(negedge clk);
    load_i = 1'b1; data_i = d; count_i = CW'(n);
    @(negedge clk);
    load_i = 1'b0;
    for (int c = 0; c < nn * SLOT; c++) begin
      logic exp_low;
      exp_low = (c % SLOT) < (d[c / SLOT] ? U : 2 * U);
      if (tx_o != !exp_low || !busy_o || done_o) begin
        bad++;
        if (first_bad < 0) first_bad = c;
      end
      if (interfere && c == 5) begin load_i = 1'b1; data_i = ~d; count_i = CW'(DW); end
      if (interfere && c == 6) load_i = 1'b0;
      @(negedge clk);
    end
    // R2 R3 R4 R5 R8 R9: waveform over every cycle of every slot
    check(bad == 0, "R2/R3/R4/R5 waveform", first_bad, -1);
    // R7: done exactly one cycle after last slot, busy low
    check(done_o && !busy_o && tx_o, "R7 done", {done_o, busy_o, tx_o}, 3'b101);
    // R6: reply bits at positions sent, zero above
    check(echo_o == (reply & mask), "R6 echo", echo_o, reply & mask);
    @(negedge clk);
    check(!done_o && tx_o && echo_o == (reply & mask), "R7 single pulse/hold",
          {done_o, tx_o}, 2'b01);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    int cnt;
    bit stray;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(tx_o && busy_o && !done_o && echo_o == '0, "R1 reset",
          {tx_o, busy_o, done_o}, 3'b110);
    rst_n = 1'b1;
    cnt = 0; stray = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      load_i = (k >= 2 && k < 12); data_i = 8'h3C; count_i = 4'd8;
      if (!tx_o || done_o) stray = 1;
      if (!busy_o) break;
      cnt++;
    end
    load_i = 1'b0;
    // R1: busy for exactly START rising edges after release
    check(cnt == START - 1, "R1 start delay", cnt, START - 1);
    repeat (30) begin
      @(negedge clk);
      if (busy_o || !tx_o || done_o) stray = 1;
    end
    // R1 R10: loads during the delay were ignored, idle line high
    check(!stray, "R1/R10 loads in delay ignored", stray, 0);

    // R9: count zero ignored
    @(negedge clk);
    load_i = 1'b1; data_i = 8'h00; count_i = '0;
    @(negedge clk);
    load_i = 1'b0;
    stray = 0;
    repeat (30) begin
      if (busy_o || !tx_o || done_o) stray = 1;
      @(negedge clk);
    end
    check(!stray, "R9 zero count ignored", stray, 0);

    // R5 R6: every bit count
    for (int n = 1; n <= DW; n++) send(8'hC6, n, 0);
    // R9: count above width clamped
    send(8'h5B, 12, 0);
    send(8'h81, 15, 0);
    // R8: load while busy ignored
    send(8'h0F, 8, 1);
    send(8'hF0, 3, 1);
    // R2 R3 R4 R5 R6 R7: all 8-bit words
    for (int w = 0; w < 256; w++) send(DW'(w), DW, 0);
    summary();
  end
endmodule